// File: doc/BRIEF.md
# Paged Address Translator with Hardware Table Walk

This block turns 32-bit logical addresses into physical addresses for 4 KB pages. The upper 20 bits of an address are the virtual page number and the lower 12 bits are the byte offset. The page number is looked up in an eight-entry, fully associative translation cache. On a hit, the cached frame number is joined to the offset and no page-table memory access takes place. On a miss, the block reads one page-table entry from memory, checks it, installs it in the cache and then answers the request.

Every access is checked in three steps. The page number is first compared against a table-length input. The entry must then be marked present. Finally, the access kind must be allowed by the entry's read, write and execute permissions. The block also keeps the referenced and modified bits of each entry up to date in memory: whenever a successful access changes either bit, the block writes the updated entry back through a dedicated write port. A flush input empties the cache when the address space changes.

Each request takes one cycle for acceptance and one cycle for lookup, plus the table read on a miss. Only one request is in flight at a time.

Top module: `pgx_translator`

## Requirements
- R1: A successful translation returns `rsp_paddr = {frame, req_vaddr[11:0]}`, with `rsp_fcode = 0`.
- R2: On a cache miss the block makes exactly one table read, at address `tbl_base + 4 * page_number`. It keeps `rd_req` high with a stable `rd_addr` until `rd_ready` is sampled high, with `rd_rdata` valid in that same cycle. A later access to the same page then needs no read.
- R3: A cache hit produces a response without any table read. `rsp_valid` rises in the second cycle after the request is accepted.
- R4: Table entry layout:
  - bit 31: present
  - bit 30: referenced
  - bit 29: modified
  - bit 28: read allowed
  - bit 27: write allowed
  - bit 26: execute allowed
  - bits 25:20: reserved
  - bits 19:0: frame

  A write-back stores the entry unchanged apart from the referenced and modified bits.
- R5: An entry with bit 31 clear gives `rsp_fcode = 2`. It is not cached, so a retry reads the table again, and it causes no write-back.
- R6: A page number greater than or equal to `tbl_len` gives `rsp_fcode = 1` with no table read. Page number `tbl_len - 1` is translated normally.
- R7: `req_kind` encoding: 0 = read, 1 = write, 2 = execute, 3 = never allowed. A kind that the entry's permission bits do not allow gives `rsp_fcode = 3` and `rsp_paddr = 0`. It causes no write-back, so neither the referenced nor the modified bit changes.
- R8: A successful access whose entry has the referenced bit clear writes the entry back, with bit 30 set, to the same address it came from. The write-back happens in the response cycle. Once the cached copy has the bit set, later accesses cause no further write.
- R9: A successful write whose entry has the modified bit clear writes the entry back with bits 30 and 29 set. Reads and executes never set bit 29.
- R10: The cache holds 8 translations. Fills replace slots in round-robin order, starting at slot 0 after reset or flush. At most one slot matches any page.
- R11: A `flush` pulse invalidates every slot and returns the replacement order to slot 0. It takes precedence over a fill in the same cycle: the request still completes, but its translation is not kept.
- R12: `req_ready` is high only while no request is in flight. `rsp_valid` is a single-cycle pulse.
- R13: After reset, `req_ready` is 1, and `rsp_valid`, `rd_req` and `wr_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| tbl_base | input | 32 | Byte address of the page table |
| tbl_len | input | 21 | Number of entries in the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Logical address |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fcode | output | 2 | 0 ok, 1 out of range, 2 not present, 3 not permitted |
| rd_req | output | 1 | Table read request |
| rd_addr | output | 32 | Table read address |
| rd_ready | input | 1 | Read data valid, completes the read |
| rd_rdata | input | 32 | Table entry read from memory |
| wr_req | output | 1 | Write-back strobe |
| wr_addr | output | 32 | Write-back address |
| wr_data | output | 32 | Updated table entry |

## Verification
The hardest situation to reach from the ports is a flush that lands in the exact cycle a table walk completes. In that case the installation must be dropped while the response still goes out. The bench's memory model knows its own read latency, so it can raise `flush` in the same cycle it returns `rd_ready`. A follow-up access to the same page must then read the table again. Round-robin eviction is also reached only by a long sequence: eight fills after a flush, a ninth that evicts slot 0, and then misses and hits that reveal which slot was replaced.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int ADDR_W   = 32;
  localparam int OFF_W    = 12;
  localparam int VPN_W    = ADDR_W - OFF_W;
  localparam int FRAME_W  = 20;
  localparam int RSV_W    = 32 - 6 - FRAME_W;
  localparam int ENT_LG   = 2;           // log2 of entry size in bytes
  localparam int LEN_W    = VPN_W + 1;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_RANGE  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PROT   = 2'd3
  } flt_e;

  // In-memory entry layout
  typedef struct packed {
    logic               v;
    logic               r;
    logic               m;
    logic               pr;
    logic               pw;
    logic               px;
    logic [RSV_W-1:0]   rsv;
    logic [FRAME_W-1:0] frame;
  } pte_t;

  // Cached payload of one translation slot
  typedef struct packed {
    logic               pr;
    logic               pw;
    logic               px;
    logic               r;
    logic               m;
    logic [RSV_W-1:0]   rsv;
    logic [FRAME_W-1:0] frame;
  } slot_t;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [VPN_W-1:0]  vpn);
    return base + (ADDR_W'(vpn) << ENT_LG);
  endfunction

  function automatic logic [ADDR_W-1:0] phys_of(input logic [FRAME_W-1:0] frame,
                                                input logic [OFF_W-1:0]   off);
    return {frame, off};
  endfunction

  function automatic logic [31:0] pte_from_slot(input slot_t s);
    pte_t p;
    p.v     = 1'b1;
    p.r     = s.r;
    p.m     = s.m;
    p.pr    = s.pr;
    p.pw    = s.pw;
    p.px    = s.px;
    p.rsv   = s.rsv;
    p.frame = s.frame;
    return p;
  endfunction

  function automatic logic in_bounds(input logic [VPN_W-1:0] vpn,
                                     input logic [LEN_W-1:0] len);
    return {1'b0, vpn} < len;
  endfunction
endpackage

// File: rtl/pgx_access_judge.sv
module pgx_access_judge
  import pgx_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       pr,
  input  logic       pw,
  input  logic       px,
  input  logic       r_in,
  input  logic       m_in,
  output logic       ok,
  output logic       r_out,
  output logic       m_out,
  output logic       need_wb
);
  always_comb begin
    unique case (acc_e'(kind))
      ACC_READ:  ok = pr;
      ACC_WRITE: ok = pw;
      ACC_EXEC:  ok = px;
      default:   ok = 1'b0;
    endcase
    r_out   = r_in | ok;
    m_out   = m_in | (ok && (acc_e'(kind) == ACC_WRITE));
    need_wb = ok && ((r_out != r_in) || (m_out != m_in));
  end
endmodule

// File: rtl/pgx_rr_victim.sv
module pgx_rr_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (clear)
      idx <= '0;
    else if (advance)
      idx <= (idx == IDX_W'(ENTRIES - 1)) ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/pgx_tlb_store.sv
module pgx_tlb_store
  import pgx_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [VPN_W-1:0]   key,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  slot_t              fill_slot,
  input  logic               upd_en,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               upd_r,
  input  logic               upd_m,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [IDX_W-1:0]   hit_idx,
  output slot_t              hit_slot,
  output logic [ENTRIES-1:0] valid_vec
);
  slot_t slots [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic             vld;
    logic [VPN_W-1:0] tag;
    slot_t            pay;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld <= 1'b0;
        tag <= '0;
        pay <= '0;
      end else if (flush) begin
        vld <= 1'b0;
      end else if (fill_en && (fill_idx == IDX_W'(g))) begin
        vld <= 1'b1;
        tag <= key;
        pay <= fill_slot;
      end else if (upd_en && (upd_idx == IDX_W'(g))) begin
        pay.r <= upd_r;
        pay.m <= upd_m;
      end
    end

    assign hit_vec[g]   = vld && (tag == key);
    assign valid_vec[g] = vld;
    assign slots[g]     = pay;
  end

  always_comb begin
    hit_idx  = '0;
    hit_slot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        hit_idx  = hit_idx | IDX_W'(i);
        hit_slot = slot_t'(hit_slot | slots[i]);
      end
    end
  end
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [LEN_W-1:0]  tbl_len,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fcode,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [31:0]       rd_rdata,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_WALK} st_e;

  st_e               st;
  logic [ADDR_W-1:0] q_va;
  logic [1:0]        q_kind;
  logic [VPN_W-1:0]  q_vpn;
  logic [OFF_W-1:0]  q_off;

  assign q_vpn = q_va[ADDR_W-1:OFF_W];
  assign q_off = q_va[OFF_W-1:0];

  // Cache store and replacement
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;
  slot_t              hit_slot;
  slot_t              walk_slot;
  slot_t              judge_slot;
  slot_t              next_slot;
  pte_t               fetched;

  // Named events
  logic in_range;
  logic ev_bounds;
  logic ev_hit;
  logic ev_miss;
  logic walk_done;
  logic ev_absent;
  logic ev_fill;
  logic ev_deny;
  logic ev_wb;
  logic ev_rsp;

  logic ok, r_new, m_new, need_wb;

  assign fetched   = pte_t'(rd_rdata);
  assign in_range  = in_bounds(q_vpn, tbl_len);
  assign ev_bounds = (st == S_CHECK) && !in_range;
  assign ev_hit    = (st == S_CHECK) && in_range && (|hit_vec);
  assign ev_miss   = (st == S_CHECK) && in_range && !(|hit_vec);
  assign walk_done = (st == S_WALK) && rd_ready;
  assign ev_absent = walk_done && !fetched.v;
  assign ev_fill   = walk_done && fetched.v;

  always_comb begin
    walk_slot.pr    = fetched.pr;
    walk_slot.pw    = fetched.pw;
    walk_slot.px    = fetched.px;
    walk_slot.r     = fetched.r;
    walk_slot.m     = fetched.m;
    walk_slot.rsv   = fetched.rsv;
    walk_slot.frame = fetched.frame;
  end

  assign judge_slot = (st == S_WALK) ? walk_slot : hit_slot;

  pgx_access_judge u_judge (
    .kind    (q_kind),
    .pr      (judge_slot.pr),
    .pw      (judge_slot.pw),
    .px      (judge_slot.px),
    .r_in    (judge_slot.r),
    .m_in    (judge_slot.m),
    .ok      (ok),
    .r_out   (r_new),
    .m_out   (m_new),
    .need_wb (need_wb)
  );

  always_comb begin
    next_slot   = judge_slot;
    next_slot.r = r_new;
    next_slot.m = m_new;
  end

  assign ev_deny = (ev_hit || ev_fill) && !ok;
  assign ev_wb   = (ev_hit || ev_fill) && need_wb;
  assign ev_rsp  = ev_bounds || ev_hit || walk_done;

  pgx_tlb_store #(.ENTRIES(ENTRIES)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .key       (q_vpn),
    .fill_en   (ev_fill),
    .fill_idx  (victim_idx),
    .fill_slot (next_slot),
    .upd_en    (ev_hit && need_wb),
    .upd_idx   (hit_idx),
    .upd_r     (r_new),
    .upd_m     (m_new),
    .hit_vec   (hit_vec),
    .hit_idx   (hit_idx),
    .hit_slot  (hit_slot),
    .valid_vec (valid_vec)
  );

  pgx_rr_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush),
    .advance (ev_fill),
    .idx     (victim_idx)
  );

  // Handshake and table read port
  assign req_ready = (st == S_IDLE);
  assign rd_req    = (st == S_WALK);
  assign rd_addr   = entry_addr(tbl_base, q_vpn);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      q_va   <= '0;
      q_kind <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          st     <= S_CHECK;
          q_va   <= req_vaddr;
          q_kind <= req_kind;
        end
        S_CHECK: st <= ev_miss ? S_WALK : S_IDLE;
        S_WALK:  if (rd_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // Registered response and write-back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fcode <= FLT_NONE;
      wr_req    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      rsp_valid <= ev_rsp;
      wr_req    <= ev_wb;
      if (ev_rsp) begin
        if (ev_bounds) begin
          rsp_fcode <= FLT_RANGE;
          rsp_paddr <= '0;
        end else if (ev_absent) begin
          rsp_fcode <= FLT_ABSENT;
          rsp_paddr <= '0;
        end else if (ev_deny) begin
          rsp_fcode <= FLT_PROT;
          rsp_paddr <= '0;
        end else begin
          rsp_fcode <= FLT_NONE;
          rsp_paddr <= phys_of(judge_slot.frame, q_off);
        end
      end
      if (ev_wb) begin
        wr_addr <= entry_addr(tbl_base, q_vpn);
        wr_data <= pte_from_slot(next_slot);
      end
    end
  end
endmodule

// File: rtl/pgx_translator_chk.sv
module pgx_translator_chk #(
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic [1:0]         rsp_fcode,
  input logic               rd_req,
  input logic               rd_ready,
  input logic [31:0]        rd_addr,
  input logic               wr_req,
  input logic [1:0]         wr_vr,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               ev_bounds
);
  p_single_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  p_range_noread_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bounds |=> (!rd_req && rsp_valid && rsp_fcode == 2'd1));

  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !req_ready);

  p_fault_nowb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fcode != 2'd0) |-> !wr_req);

  p_wb_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (rsp_valid && rsp_fcode == 2'd0 && wr_vr == 2'b11));

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
endmodule

bind pgx_translator pgx_translator_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush     (flush),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_fcode (rsp_fcode),
  .rd_req    (rd_req),
  .rd_ready  (rd_ready),
  .rd_addr   (rd_addr),
  .wr_req    (wr_req),
  .wr_vr     (wr_data[31:30]),
  .hit_vec   (hit_vec),
  .valid_vec (valid_vec),
  .ev_bounds (ev_bounds)
);

// File: tb/pgx_translator_tb.sv
`timescale 1ns/1ps
module pgx_translator_tb;
  localparam logic [31:0] BASE = 32'h0004_0000;
  localparam int          LEN  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_task = 1'b0;
  logic        flush_auto = 1'b0;
  logic        flush_arm = 1'b0;
  logic        flush;
  logic [31:0] tbl_base = BASE;
  logic [20:0] tbl_len = 21'(LEN);
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fcode;
  logic        rd_req;
  logic [31:0] rd_addr;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_rdata = '0;
  logic        wr_req;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;

  assign flush = flush_task | flush_auto;

  always #2.5 clk = ~clk;

  pgx_translator u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .tbl_base(tbl_base), .tbl_len(tbl_len),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fcode(rsp_fcode),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_rdata(rd_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // Entry: {present, ref, mod, rd, wr, ex, rsv[5:0], frame[19:0]}
  function automatic logic [31:0] mk(input bit v, r, m, pr, pw, px,
                                     input logic [5:0] rsv, input logic [19:0] fr);
    return {v, r, m, pr, pw, px, rsv, fr};
  endfunction

  function automatic logic [31:0] init_pte(input int i);
    if (i == 3)  return mk(1, 0, 0, 1, 0, 0, 6'h00, 20'h12345);
    if (i == 5)  return mk(1, 0, 0, 1, 1, 0, 6'h2A, 20'h0ABCD);
    if (i == 7)  return mk(0, 0, 0, 1, 1, 1, 6'h00, 20'h55555);
    if (i == 9)  return mk(1, 1, 0, 0, 0, 1, 6'h00, 20'h00777);
    if (i == 39) return mk(1, 1, 0, 1, 0, 0, 6'h00, 20'hFFFFF);
    if (i >= 20 && i <= 28) return mk(1, 1, 0, 1, 0, 0, 6'h00, 20'h00100 + 20'(i));
    return 32'h0;
  endfunction

  function automatic int widx(input logic [31:0] a);
    return int'((a - BASE) >> 2) & 63;
  endfunction

  // Page-table memory model: fixed read latency, write port always accepts
  logic [31:0] mem [64];
  int          lat_cnt = 0;
  int          rd_total = 0;
  int          wr_total = 0;
  logic [31:0] last_rd_addr = '0;
  logic [31:0] last_wr_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_pte(i);
      rd_ready   <= 1'b0;
      flush_auto <= 1'b0;
      lat_cnt    <= 0;
    end else begin
      rd_ready   <= 1'b0;
      flush_auto <= 1'b0;
      if (rd_req && !rd_ready) begin
        if (lat_cnt == 2) begin
          rd_ready     <= 1'b1;
          rd_rdata     <= mem[widx(rd_addr)];
          rd_total     <= rd_total + 1;
          last_rd_addr <= rd_addr;
          lat_cnt      <= 0;
          flush_auto   <= flush_arm;
        end else begin
          lat_cnt <= lat_cnt + 1;
        end
      end
      if (wr_req) begin
        mem[widx(wr_addr)] <= wr_data;
        wr_total           <= wr_total + 1;
        last_wr_addr       <= wr_addr;
      end
    end
  end

  int checks = 0;
  int errors = 0;
  logic [31:0] got_pa;
  logic [1:0]  got_fc;
  int d_rd, d_wr, lat_seen;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_access(input logic [31:0] va, input logic [1:0] k);
    int rd0 = rd_total;
    int wr0 = wr_total;
    int guard = 0;
    @(negedge clk);
    req_vaddr = va;
    req_kind  = k;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat_seen  = 1;
    while (!rsp_valid && guard < 50) begin
      @(negedge clk);
      guard++;
      lat_seen++;
    end
    got_pa = rsp_paddr;
    got_fc = rsp_fcode;
    @(posedge clk);
    #1;
    d_rd = rd_total - rd0;
    d_wr = wr_total - wr0;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush_task = 1'b1;
    @(negedge clk);
    flush_task = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 req_ready", 32'(req_ready), 32'd1);
    chk("R13 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R13 rd_req",    32'(rd_req),    32'd0);
    chk("R13 wr_req",    32'(wr_req),    32'd0);
  endtask

  task automatic t_miss_fill();
    do_access({20'd3, 12'hABC}, 2'd0);
    chk("R1 miss paddr",  got_pa, 32'h12345ABC);
    chk("R1 miss fcode",  32'(got_fc), 32'd0);
    chk("R2 one read",    32'(d_rd), 32'd1);
    chk("R2 read addr",   last_rd_addr, BASE + 32'd12);
    chk("R8 ref wb count", 32'(d_wr), 32'd1);
    chk("R8 ref wb addr", last_wr_addr, BASE + 32'd12);
    chk("R8 ref set",     mem[3], init_pte(3) | 32'h4000_0000);
  endtask

  task automatic t_hit();
    do_access({20'd3, 12'h004}, 2'd0);
    chk("R3 hit paddr",   got_pa, 32'h12345004);
    chk("R3 hit no read", 32'(d_rd), 32'd0);
    chk("R3 hit latency", 32'(lat_seen), 32'd2);
    chk("R8 no repeat wb", 32'(d_wr), 32'd0);
  endtask

  task automatic t_perm();
    do_access({20'd3, 12'h010}, 2'd1);
    chk("R7 write denied code",  32'(got_fc), 32'd3);
    chk("R7 write denied paddr", got_pa, 32'h0);
    chk("R7 denied no wb",       32'(d_wr), 32'd0);
    chk("R7 mod bit clear",      32'(mem[3][29]), 32'd0);
    do_access({20'd3, 12'h010}, 2'd3);
    chk("R7 kind3 denied",       32'(got_fc), 32'd3);
  endtask

  task automatic t_dirty();
    do_access({20'd5, 12'h123}, 2'd0);
    chk("R9 read paddr",    got_pa, 32'h0ABCD123);
    chk("R9 read no mod",   mem[5], init_pte(5) | 32'h4000_0000);
    do_access({20'd5, 12'h456}, 2'd1);
    chk("R9 write paddr",   got_pa, 32'h0ABCD456);
    chk("R9 write hit",     32'(d_rd), 32'd0);
    chk("R9 write wb",      32'(d_wr), 32'd1);
    chk("R4 rsv kept, mod set", mem[5], init_pte(5) | 32'h6000_0000);
    do_access({20'd5, 12'h000}, 2'd1);
    chk("R9 second write no wb", 32'(d_wr), 32'd0);
  endtask

  task automatic t_absent();
    do_access({20'd7, 12'h000}, 2'd0);
    chk("R5 absent code",   32'(got_fc), 32'd2);
    chk("R5 absent read",   32'(d_rd), 32'd1);
    chk("R5 absent no wb",  32'(d_wr), 32'd0);
    do_access({20'd7, 12'h000}, 2'd0);
    chk("R5 absent retry reads", 32'(d_rd), 32'd1);
  endtask

  task automatic t_bounds();
    do_access({20'd40, 12'h000}, 2'd0);
    chk("R6 out of range code", 32'(got_fc), 32'd1);
    chk("R6 out of range read", 32'(d_rd), 32'd0);
    do_access({20'd39, 12'h0FF}, 2'd0);
    chk("R6 last page code",  32'(got_fc), 32'd0);
    chk("R6 last page paddr", got_pa, 32'hFFFFF0FF);
  endtask

  task automatic t_exec();
    do_access({20'd9, 12'h800}, 2'd2);
    chk("R7 exec paddr", got_pa, 32'h00777800);
    chk("R7 exec no wb", 32'(d_wr), 32'd0);
    do_access({20'd9, 12'h800}, 2'd0);
    chk("R7 read on exec-only", 32'(got_fc), 32'd3);
  endtask

  task automatic t_flush();
    pulse_flush();
    do_access({20'd3, 12'h000}, 2'd0);
    chk("R11 flush forces read", 32'(d_rd), 32'd1);
  endtask

  task automatic t_flush_race();
    int total;
    pulse_flush();
    flush_arm = 1'b1;
    do_access({20'd21, 12'h321}, 2'd0);
    flush_arm = 1'b0;
    chk("R11 race response", got_pa, 32'h00115321);
    do_access({20'd21, 12'h000}, 2'd0);
    chk("R11 race fill dropped", 32'(d_rd), 32'd1);
    do_access({20'd21, 12'h000}, 2'd0);
    chk("R11 refill kept", 32'(d_rd), 32'd0);
    total = 0;
  endtask

  task automatic t_replace();
    int misses;
    pulse_flush();
    misses = 0;
    for (int p = 20; p < 28; p++) begin
      do_access({20'(p), 12'h000}, 2'd0);
      misses += d_rd;
    end
    chk("R10 eight fills", 32'(misses), 32'd8);
    misses = 0;
    for (int p = 20; p < 28; p++) begin
      do_access({20'(p), 12'h000}, 2'd0);
      misses += d_rd;
    end
    chk("R10 eight resident", 32'(misses), 32'd0);
    do_access({20'd28, 12'h000}, 2'd0);
    chk("R10 ninth fills", 32'(d_rd), 32'd1);
    do_access({20'd21, 12'h000}, 2'd0);
    chk("R10 slot1 kept", 32'(d_rd), 32'd0);
    do_access({20'd20, 12'h000}, 2'd0);
    chk("R10 slot0 evicted", 32'(d_rd), 32'd1);
    do_access({20'd21, 12'h000}, 2'd0);
    chk("R10 slot1 next victim", 32'(d_rd), 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_miss_fill();
    t_hit();
    t_perm();
    t_dirty();
    t_absent();
    t_bounds();
    t_exec();
    t_flush();
    t_replace();
    t_flush_race();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule